// File: doc/BRIEF.md
# R/I-format instruction decoder

A purely combinational decoder for 32-bit fixed-length instructions. It covers two groups. The register-register group (opcode 0) holds the arithmetic, logic, compare and shift operations, plus the hi/lo move and multiply/divide operations. The immediate group holds the immediate arithmetic, logic and compare operations and load-upper-immediate. For each word it produces the following, all in the same cycle:

- the two source register addresses;
- the destination index and a register-write enable;
- an ALU operation code;
- the constant shift amount and a flag saying the shift amount comes from a register;
- a select between the second register operand and an immediate;
- the immediate, extended to 32 bits.

The immediate is extended according to the operation. Add and compare forms, including the unsigned compare, sign-extend it. The logic forms zero-extend it. Load-upper places it in the top half of the word.

The destination is taken from bits [15:11] for register-register words and from bits [20:16] for immediate words. Anything outside the supported set is flagged illegal. An illegal word drives every other control output to zero, so it cannot write a register. Loads, stores, branches and jumps fall into this illegal set.

Top module: `instr_decoder`

## Requirements
- R1: `rs_addr_o` always equals instr[25:21] and `rt_addr_o` always equals instr[20:16], whatever the word.
- R2: With opcode instr[31:26]=0, the decoder uses instr[15:11] as the destination and sets `reg_wr_o`=1 and `use_imm_o`=0. `alu_op_o` is set from the function field instr[5:0] as follows:
  - 0x20 gives 0 (add) and 0x21 gives 1 (add, no trap).
  - 0x22 gives 2 (sub) and 0x23 gives 3 (sub, no trap).
  - 0x24 gives 4 (and), 0x25 gives 5 (or), 0x26 gives 6 (xor) and 0x27 gives 7 (nor).
  - 0x2a gives 8 (signed less-than) and 0x2b gives 9 (unsigned less-than).
- R3: Any opcode other than 0 or 8..15 makes the word illegal, and so does any opcode-0 function not listed in R2, R8, R9 or R10. An illegal word sets `illegal_o`=1 and drives `reg_wr_o`, `use_imm_o`, `shift_var_o`, `dst_addr_o`, `alu_op_o`, `shamt_o` and `imm_o` to 0.
- R4: Opcodes 8..15 use instr[20:16] as the destination and set `use_imm_o`=1 and `reg_wr_o`=1. `alu_op_o` is set from the opcode as follows:
  - 8 gives 0 and 9 gives 1.
  - 10 gives 8 and 11 gives 9.
  - 12 gives 4, 13 gives 5 and 14 gives 6.
  - 15 gives 13 (load upper).
- R5: For opcodes 8, 9, 10 and 11, `imm_o` is instr[15:0] sign-extended, including for the unsigned compare (11).
- R6: For opcodes 12, 13 and 14, `imm_o` is instr[15:0] zero-extended. For example, an OR-immediate with 0xffff yields 0x0000ffff.
- R7: For opcode 15, `imm_o` is {instr[15:0], 16'h0000}.
- R8: Functions 0x00, 0x02 and 0x03 are constant shifts. They give `alu_op_o` 10, 11 and 12 (left logical, right logical, right arithmetic), with `shamt_o`=instr[10:6] and `shift_var_o`=0. Such a word is illegal unless instr[25:21]=0.
- R9: Functions 0x04, 0x06 and 0x07 are variable shifts. They give `alu_op_o` 10, 11 and 12 with `shift_var_o`=1 and `shamt_o`=0. The shift amount then comes from the register named by instr[25:21], and the shifted operand from instr[20:16].
- R10: Functions 0x18, 0x19, 0x1a and 0x1b (alu codes 18..21: signed and unsigned multiply, signed and unsigned divide) and functions 0x11 and 0x13 (alu 16 and 17: move to hi, move to lo) set `reg_wr_o`=0 and `dst_addr_o`=0. Functions 0x10 and 0x12 (alu 14 and 15: move from hi, move from lo) set `reg_wr_o`=1 with destination instr[15:11].
- R11: The all-zero word is legal. It decodes as a left shift by 0 with `reg_wr_o`=1 and `dst_addr_o`=0, that is, a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_addr_o | output | 5 | First source register address |
| rt_addr_o | output | 5 | Second source register address |
| dst_addr_o | output | 5 | Destination register index |
| reg_wr_o | output | 1 | General register write enable |
| alu_op_o | output | 5 | Operation code |
| shamt_o | output | 5 | Constant shift amount |
| shift_var_o | output | 1 | Shift amount taken from register rs |
| use_imm_o | output | 1 | Second operand is the immediate |
| imm_o | output | 32 | Extended immediate |
| illegal_o | output | 1 | Unsupported instruction |

## Verification
A constant shift and the illegal qualification can apply to the same word. A left shift whose bits [25:21] are not zero carries a valid shift amount and a legal-looking function code, yet it must come out illegal with every control output cleared. The bench provokes this with a shift word whose first register field is 1. It checks that the shift amount and write enable are suppressed, and a neighbouring vector with that field at zero confirms the same shift decodes normally. A full sweep of the function field with that register field at zero then separates the legal codes from the illegal ones.

// File: rtl/instr_decoder.sv
module instr_decoder (
  input  logic [31:0] instr_i,
  output logic [4:0]  rs_addr_o,
  output logic [4:0]  rt_addr_o,
  output logic [4:0]  dst_addr_o,
  output logic        reg_wr_o,
  output logic [4:0]  alu_op_o,
  output logic [4:0]  shamt_o,
  output logic        shift_var_o,
  output logic        use_imm_o,
  output logic [31:0] imm_o,
  output logic        illegal_o
);
  localparam logic [4:0] OP_ADD = 5'd0, OP_ADDU = 5'd1, OP_SUB = 5'd2, OP_SUBU = 5'd3,
                         OP_AND = 5'd4, OP_OR = 5'd5, OP_XOR = 5'd6, OP_NOR = 5'd7,
                         OP_SLT = 5'd8, OP_SLTU = 5'd9, OP_SHL = 5'd10, OP_SHR = 5'd11,
                         OP_SAR = 5'd12, OP_LUP = 5'd13, OP_RDHI = 5'd14, OP_RDLO = 5'd15,
                         OP_WRHI = 5'd16, OP_WRLO = 5'd17, OP_MUL = 5'd18, OP_MULU = 5'd19,
                         OP_DIV = 5'd20, OP_DIVU = 5'd21;

  logic [5:0]  opc, fn;
  logic [4:0]  f_rs, f_rt, f_rd, f_sa;
  logic [15:0] k16;
  logic [31:0] k_sx, k_zx;

  assign opc  = instr_i[31:26];
  assign f_rs = instr_i[25:21];
  assign f_rt = instr_i[20:16];
  assign f_rd = instr_i[15:11];
  assign f_sa = instr_i[10:6];
  assign fn   = instr_i[5:0];
  assign k16  = instr_i[15:0];
  assign k_sx = {{16{k16[15]}}, k16};
  assign k_zx = {16'h0000, k16};

  assign rs_addr_o = f_rs;
  assign rt_addr_o = f_rt;

  logic        bad, wr, uimm, vsh;
  logic [4:0]  dst, op, sh;
  logic [31:0] kx;

  always_comb begin
    bad  = 1'b0;
    wr   = 1'b1;
    uimm = 1'b0;
    vsh  = 1'b0;
    dst  = f_rd;
    op   = OP_ADD;
    sh   = 5'd0;
    kx   = 32'h0;
    if (opc == 6'd0) begin
      case (fn)
        6'h00: begin op = OP_SHL; sh = f_sa; bad = (f_rs != 5'd0); end
        6'h02: begin op = OP_SHR; sh = f_sa; bad = (f_rs != 5'd0); end
        6'h03: begin op = OP_SAR; sh = f_sa; bad = (f_rs != 5'd0); end
        6'h04: begin op = OP_SHL; vsh = 1'b1; end
        6'h06: begin op = OP_SHR; vsh = 1'b1; end
        6'h07: begin op = OP_SAR; vsh = 1'b1; end
        6'h10: op = OP_RDHI;
        6'h12: op = OP_RDLO;
        6'h11: begin op = OP_WRHI; wr = 1'b0; dst = 5'd0; end
        6'h13: begin op = OP_WRLO; wr = 1'b0; dst = 5'd0; end
        6'h18: begin op = OP_MUL;  wr = 1'b0; dst = 5'd0; end
        6'h19: begin op = OP_MULU; wr = 1'b0; dst = 5'd0; end
        6'h1a: begin op = OP_DIV;  wr = 1'b0; dst = 5'd0; end
        6'h1b: begin op = OP_DIVU; wr = 1'b0; dst = 5'd0; end
        6'h20: op = OP_ADD;
        6'h21: op = OP_ADDU;
        6'h22: op = OP_SUB;
        6'h23: op = OP_SUBU;
        6'h24: op = OP_AND;
        6'h25: op = OP_OR;
        6'h26: op = OP_XOR;
        6'h27: op = OP_NOR;
        6'h2a: op = OP_SLT;
        6'h2b: op = OP_SLTU;
        default: bad = 1'b1;
      endcase
    end else begin
      uimm = 1'b1;
      dst  = f_rt;
      case (opc)
        6'd8:  begin op = OP_ADD;  kx = k_sx; end
        6'd9:  begin op = OP_ADDU; kx = k_sx; end
        6'd10: begin op = OP_SLT;  kx = k_sx; end
        6'd11: begin op = OP_SLTU; kx = k_sx; end
        6'd12: begin op = OP_AND;  kx = k_zx; end
        6'd13: begin op = OP_OR;   kx = k_zx; end
        6'd14: begin op = OP_XOR;  kx = k_zx; end
        6'd15: begin op = OP_LUP;  kx = {k16, 16'h0000}; end
        default: bad = 1'b1;
      endcase
    end
    if (bad) begin
      wr   = 1'b0;
      uimm = 1'b0;
      vsh  = 1'b0;
      dst  = 5'd0;
      op   = 5'd0;
      sh   = 5'd0;
      kx   = 32'h0;
    end
  end

  assign illegal_o   = bad;
  assign reg_wr_o    = wr;
  assign use_imm_o   = uimm;
  assign shift_var_o = vsh;
  assign dst_addr_o  = dst;
  assign alu_op_o    = op;
  assign shamt_o     = sh;
  assign imm_o       = kx;
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk (
  input logic [31:0] instr_i,
  input logic [4:0]  rs_addr_o,
  input logic [4:0]  rt_addr_o,
  input logic [4:0]  dst_addr_o,
  input logic        reg_wr_o,
  input logic [4:0]  alu_op_o,
  input logic [4:0]  shamt_o,
  input logic        shift_var_o,
  input logic        use_imm_o,
  input logic [31:0] imm_o,
  input logic        illegal_o
);
  logic [5:0] opc;
  assign opc = instr_i[31:26];

  always_comb begin
    if (!$isunknown(instr_i)) begin
      a_r1_fields: assert (rs_addr_o == instr_i[25:21] && rt_addr_o == instr_i[20:16])
        else $error("a_r1_fields");
      a_r3_no_write_when_illegal: assert (!(illegal_o && (reg_wr_o || use_imm_o)))
        else $error("a_r3_no_write_when_illegal");
      a_r4_imm_only_itype: assert (!use_imm_o || opc != 6'd0)
        else $error("a_r4_imm_only_itype");
      a_r5_sign_ext: assert (!(opc >= 6'd8 && opc <= 6'd11) || imm_o[31:16] == {16{instr_i[15]}})
        else $error("a_r5_sign_ext");
      a_r6_zero_ext: assert (!(opc >= 6'd12 && opc <= 6'd14) || imm_o[31:16] == 16'h0)
        else $error("a_r6_zero_ext");
      a_r7_upper: assert (opc != 6'd15 || imm_o[15:0] == 16'h0)
        else $error("a_r7_upper");
      a_r9_var_no_shamt: assert (!shift_var_o || shamt_o == 5'd0)
        else $error("a_r9_var_no_shamt");
      a_r10_hilo_no_write: assert (!(alu_op_o >= 5'd16 && alu_op_o <= 5'd21) || !reg_wr_o)
        else $error("a_r10_hilo_no_write");
    end
  end
endmodule

bind instr_decoder instr_decoder_chk u_chk (.*);

// File: tb/tb_instr_decoder.sv
module tb_instr_decoder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] instr_i;
  logic [4:0]  rs_addr_o, rt_addr_o, dst_addr_o, alu_op_o, shamt_o;
  logic        reg_wr_o, shift_var_o, use_imm_o, illegal_o;
  logic [31:0] imm_o;

  instr_decoder dut (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam int N = 28;
  // {instr, illegal, wr, use_imm, var, dst, alu, shamt, imm}
  localparam logic [82:0] VEC [N] = '{
    {{6'd0,5'd3,5'd4,5'd2,5'd0,6'h20},   1'b0,1'b1,1'b0,1'b0,5'd2,5'd0,5'd0,32'h0},
    {{6'd0,5'd6,5'd7,5'd5,5'd0,6'h22},   1'b0,1'b1,1'b0,1'b0,5'd5,5'd2,5'd0,32'h0},
    {{6'd0,5'd1,5'd2,5'd9,5'd0,6'h27},   1'b0,1'b1,1'b0,1'b0,5'd9,5'd7,5'd0,32'h0},
    {{6'd0,5'd1,5'd2,5'd10,5'd0,6'h2b},  1'b0,1'b1,1'b0,1'b0,5'd10,5'd9,5'd0,32'h0},
    {{6'd0,5'd0,5'd3,5'd2,5'd4,6'h00},   1'b0,1'b1,1'b0,1'b0,5'd2,5'd10,5'd4,32'h0},
    {{6'd0,5'd0,5'd1,5'd8,5'd31,6'h03},  1'b0,1'b1,1'b0,1'b0,5'd8,5'd12,5'd31,32'h0},
    {{6'd0,5'd1,5'd3,5'd2,5'd4,6'h00},   1'b1,1'b0,1'b0,1'b0,5'd0,5'd0,5'd0,32'h0},
    {{6'd0,5'd9,5'd8,5'd4,5'd0,6'h06},   1'b0,1'b1,1'b0,1'b1,5'd4,5'd11,5'd0,32'h0},
    {{6'd0,5'd9,5'd8,5'd4,5'd0,6'h07},   1'b0,1'b1,1'b0,1'b1,5'd4,5'd12,5'd0,32'h0},
    {{6'd0,5'd3,5'd4,5'd0,5'd0,6'h18},   1'b0,1'b0,1'b0,1'b0,5'd0,5'd18,5'd0,32'h0},
    {{6'd0,5'd3,5'd0,5'd0,5'd0,6'h11},   1'b0,1'b0,1'b0,1'b0,5'd0,5'd16,5'd0,32'h0},
    {{6'd0,5'd0,5'd0,5'd12,5'd0,6'h10},  1'b0,1'b1,1'b0,1'b0,5'd12,5'd14,5'd0,32'h0},
    {{6'd0,5'd0,5'd0,5'd13,5'd0,6'h12},  1'b0,1'b1,1'b0,1'b0,5'd13,5'd15,5'd0,32'h0},
    {{6'd0,5'd3,5'd4,5'd0,5'd0,6'h1b},   1'b0,1'b0,1'b0,1'b0,5'd0,5'd21,5'd0,32'h0},
    {{6'd13,5'd3,5'd2,16'h0004},         1'b0,1'b1,1'b1,1'b0,5'd2,5'd5,5'd0,32'h0000_0004},
    {{6'd13,5'd0,5'd8,16'hffff},         1'b0,1'b1,1'b1,1'b0,5'd8,5'd5,5'd0,32'h0000_ffff},
    {{6'd12,5'd9,5'd8,16'h8000},         1'b0,1'b1,1'b1,1'b0,5'd8,5'd4,5'd0,32'h0000_8000},
    {{6'd14,5'd9,5'd7,16'hf00f},         1'b0,1'b1,1'b1,1'b0,5'd7,5'd6,5'd0,32'h0000_f00f},
    {{6'd8,5'd0,5'd8,16'hffff},          1'b0,1'b1,1'b1,1'b0,5'd8,5'd0,5'd0,32'hffff_ffff},
    {{6'd9,5'd2,5'd3,16'h8000},          1'b0,1'b1,1'b1,1'b0,5'd3,5'd1,5'd0,32'hffff_8000},
    {{6'd10,5'd9,5'd8,16'h7fff},         1'b0,1'b1,1'b1,1'b0,5'd8,5'd8,5'd0,32'h0000_7fff},
    {{6'd11,5'd9,5'd8,16'hfffe},         1'b0,1'b1,1'b1,1'b0,5'd8,5'd9,5'd0,32'hffff_fffe},
    {{6'd15,5'd0,5'd8,16'h1234},         1'b0,1'b1,1'b1,1'b0,5'd8,5'd13,5'd0,32'h1234_0000},
    {32'h0000_0000,                      1'b0,1'b1,1'b0,1'b0,5'd0,5'd10,5'd0,32'h0},
    {{6'd0,5'd3,5'd4,5'd2,5'd0,6'h01},   1'b1,1'b0,1'b0,1'b0,5'd0,5'd0,5'd0,32'h0},
    {{6'd35,5'd29,5'd4,16'h0010},        1'b1,1'b0,1'b0,1'b0,5'd0,5'd0,5'd0,32'h0},
    {{6'd0,5'd3,5'd4,5'd2,5'd0,6'h28},   1'b1,1'b0,1'b0,1'b0,5'd0,5'd0,5'd0,32'h0},
    {{6'd2,26'h0000123},                 1'b1,1'b0,1'b0,1'b0,5'd0,5'd0,5'd0,32'h0}
  };

  string tg [N];

  task automatic apply(input logic [31:0] w);
    @(posedge clk);
    instr_i = w;
    @(negedge clk);
  endtask

  function automatic logic [50:0] got();
    return {illegal_o, reg_wr_o, use_imm_o, shift_var_o, dst_addr_o, alu_op_o, shamt_o, imm_o};
  endfunction

  initial begin
    tg = '{"R2","R2","R2","R2","R8","R8","R8","R9","R9","R10","R10","R10","R10","R10",
           "R4","R6","R6","R6","R5","R5","R5","R5","R7","R11","R3","R3","R3","R3"};
    instr_i = 32'h0;
    @(negedge clk);
    // R11: all-zero word at start is a legal no-op writing register 0
    checks++;
    if (got() != {1'b0,1'b1,1'b0,1'b0,5'd0,5'd10,5'd0,32'h0}) begin
      fails++;
      $display("FAIL R11 idle word: got %h expected %h", got(), {1'b0,1'b1,1'b0,1'b0,5'd0,5'd10,5'd0,32'h0});
    end

    for (int i = 0; i < N; i++) begin
      apply(VEC[i][82:51]);
      checks++;
      if (got() !== VEC[i][50:0]) begin
        fails++;
        $display("FAIL %s vec %0d instr %h: got %h expected %h", tg[i], i, VEC[i][82:51], got(), VEC[i][50:0]);
      end
      checks++;
      if (rs_addr_o !== VEC[i][76:72] || rt_addr_o !== VEC[i][71:67]) begin
        fails++;
        $display("FAIL R1 vec %0d: got rs %0d rt %0d expected rs %0d rt %0d", i, rs_addr_o, rt_addr_o,
                 VEC[i][76:72], VEC[i][71:67]);
      end
    end

    // R3: opcode sweep
    for (int op = 0; op < 64; op++) begin
      logic exp_bad;
      exp_bad = !(op == 0 || (op >= 8 && op <= 15));
      apply({op[5:0], 5'd4, 5'd5, 5'd6, 5'd0, 6'h21});
      checks++;
      if (illegal_o !== exp_bad || reg_wr_o !== !exp_bad) begin
        fails++;
        $display("FAIL R3 opcode %0d: got ill %b wr %b expected ill %b wr %b", op, illegal_o, reg_wr_o, exp_bad, !exp_bad);
      end
    end

    // R2/R8/R9/R10/R3: function sweep with rs field zero
    for (int f = 0; f < 64; f++) begin
      logic ok;
      ok = f inside {6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07, 6'h10, 6'h11, 6'h12, 6'h13,
                     6'h18, 6'h19, 6'h1a, 6'h1b, [6'h20:6'h27], 6'h2a, 6'h2b};
      apply({6'd0, 5'd0, 5'd7, 5'd3, 5'd0, f[5:0]});
      checks++;
      if (illegal_o !== !ok || use_imm_o !== 1'b0) begin
        fails++;
        $display("FAIL R3 function %0h: got ill %b imm %b expected ill %b imm 0", f, illegal_o, use_imm_o, !ok);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule